// File: doc/BRIEF.md
# Half-Precision Widening Converter

This block takes one 16-bit binary16 word and widens it to a binary32 word, or to a binary64 word when the `WIDE_DOUBLE` parameter is set. A caller raises `start_i` for one cycle with the word on `half_i`. When the wide value is ready, `done_o` pulses for one cycle and `result_o` carries it. `result_o` then holds that value until the next conversion completes.

Zero, normal numbers, infinity and NaN all finish in a single cycle. A half subnormal has no implicit leading one. The block normalizes it with a loop that shifts the fraction left by one bit per clock and lowers the exponent by one per shift. The wait therefore depends on the data. While the loop runs, `busy_o` is high and any new start is dropped.

A NaN keeps its 10-bit payload in the lowest bits of the wide significand. No signaling-NaN quieting is done and no exception flags are raised.

Top module: `f16_widener`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `done_o`, `busy_o` and `result_o` are all zero.
- R2: An input whose exponent field (bits 14:10) is 0 and whose fraction (bits 9:0) is 0 gives a wide zero that keeps the input sign.
- R3: An input whose exponent field `e` lies between 1 and 30 gives a wide exponent of `e - 15 + BIAS`, with BIAS equal to 127 or 1023. The 10 fraction bits are placed at the top of the wide significand and every lower significand bit is zero. The wide word is laid out as sign at the MSB, then the exponent field, then the significand.
- R4: An input with exponent field 31 and fraction 0 gives an all-ones wide exponent and a zero wide significand.
- R5: An input with exponent field 31 and a nonzero fraction gives an all-ones wide exponent. The wide significand equals the 10-bit fraction, zero-extended into its lowest bits.
- R6: An input with exponent field 0 and a nonzero fraction whose highest set bit is at position `p` gives a wide exponent of `BIAS - 24 + p`. The top 10 bits of the wide significand hold the fraction shifted left by `10 - p` and truncated to 10 bits. Every lower significand bit is zero.
- R7: Latency is counted in rising edges, starting with the edge that samples `start_i`. `done_o` is high after 1 edge for every input except a subnormal, and after `11 - p` edges for a subnormal. `busy_o` is high during a subnormal's wait.
- R8: A start raised while `busy_o` is high is ignored. It changes neither the result nor the timing of the conversion in progress, and it produces no later `done_o`.
- R9: `done_o` is high for exactly one cycle per accepted conversion. `result_o` changes only on a cycle where `done_o` rises, and holds its value afterwards.
- R10: The MSB of `result_o` equals bit 15 of the converted input in every case.
- R11: The normalization loop performs at most 10 shifts, so the smallest subnormal (only bit 0 set) takes 11 edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to convert `half_i` |
| half_i | input | 16 | binary16 input word |
| busy_o | output | 1 | High while a subnormal is being normalized |
| done_o | output | 1 | One-cycle pulse when `result_o` is updated |
| result_o | output | 32 or 64 | Wide result (64 bits when `WIDE_DOUBLE` is set) |

## Verification
The assertions assume that `start_i` is a single-cycle pulse and that a caller starts a new conversion only after seeing `done_o`. The one exception is a deliberate overlap, where a start is sent while `busy_o` is high. The normalizer's checks also assume it is loaded only with a nonzero fraction. The top level guarantees this by loading it only for a subnormal input.

The stimulus keeps within these assumptions by raising `start_i` for one clock, waiting for `done_o`, and idling a cycle before the next request. A single scenario breaks this pattern on purpose to exercise the drop rule.

// File: rtl/f16w_pkg.sv
package f16w_pkg;

    localparam int HALF_W      = 16;
    localparam int HALF_MAN_W  = 10;
    localparam int HALF_EXP_W  = 5;
    localparam int HALF_BIAS   = 15;
    localparam int NORM_STEP_W = 4;

    typedef enum logic [2:0] {
        CLS_ZERO,
        CLS_SUB,
        CLS_NORMAL,
        CLS_INF,
        CLS_NAN
    } half_class_e;

    typedef struct packed {
        logic                  sign;
        logic [HALF_EXP_W-1:0] exp;
        logic [HALF_MAN_W-1:0] frac;
        half_class_e           cls;
    } half_fields_t;

endpackage

// File: rtl/f16w_classify.sv
module f16w_classify
    import f16w_pkg::*;
(
    input  logic [HALF_W-1:0] word_i,
    output half_fields_t      fields_o
);

    always_comb begin
        fields_o.sign = word_i[HALF_W-1];
        fields_o.exp  = word_i[HALF_W-2 -: HALF_EXP_W];
        fields_o.frac = word_i[HALF_MAN_W-1:0];
        if (&fields_o.exp) begin
            fields_o.cls = (|fields_o.frac) ? CLS_NAN : CLS_INF;
        end else if (fields_o.exp == '0) begin
            fields_o.cls = (|fields_o.frac) ? CLS_SUB : CLS_ZERO;
        end else begin
            fields_o.cls = CLS_NORMAL;
        end
    end

endmodule

// File: rtl/f16w_normalizer.sv
module f16w_normalizer
    import f16w_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load_i,
    input  logic [HALF_MAN_W-1:0]  frac_i,
    output logic                   active_o,
    output logic                   finish_o,
    output logic [HALF_MAN_W-1:0]  frac_o,
    output logic [NORM_STEP_W-1:0] steps_o
);

    localparam int SIG_W     = HALF_MAN_W + 1;
    localparam int MAX_STEPS = HALF_MAN_W;

    typedef struct packed {
        logic                   active;
        logic [SIG_W-1:0]       sig;
        logic [NORM_STEP_W-1:0] steps;
    } norm_state_t;

    norm_state_t      st_d, st_q;
    logic [SIG_W-1:0] shifted;

    always_comb begin
        st_d     = st_q;
        shifted  = st_q.sig << 1;
        finish_o = 1'b0;
        if (st_q.active) begin
            st_d.sig   = shifted;
            st_d.steps = st_q.steps + NORM_STEP_W'(1);
            if (shifted[SIG_W-1]) begin
                finish_o    = 1'b1;
                st_d.active = 1'b0;
            end
        end else if (load_i) begin
            st_d.active = 1'b1;
            st_d.sig    = {1'b0, frac_i};
            st_d.steps  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = st_q.active;
    assign frac_o   = shifted[HALF_MAN_W-1:0];
    assign steps_o  = st_q.steps + NORM_STEP_W'(1);

    // R11
    step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.active |-> (int'(st_q.steps) < MAX_STEPS));

    // R7
    load_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !st_q.active) |=> st_q.active);

    // R6
    load_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !st_q.active) |-> (frac_i != '0));

endmodule

// File: rtl/f16w_pack.sv
module f16w_pack
    import f16w_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  half_fields_t           fields_i,
    input  logic [HALF_MAN_W-1:0]  norm_frac_i,
    input  logic [NORM_STEP_W-1:0] norm_steps_i,
    output logic [EXP_W+MAN_W:0]   word_o
);

    localparam int BIAS = (1 << (EXP_W - 1)) - 1;

    logic [EXP_W-1:0] exp_w;
    logic [MAN_W-1:0] man_w;

    always_comb begin
        exp_w = '0;
        man_w = '0;
        case (fields_i.cls)
            CLS_INF: begin
                exp_w = '1;
            end
            CLS_NAN: begin
                exp_w                   = '1;
                man_w[HALF_MAN_W-1:0]   = fields_i.frac;
            end
            CLS_NORMAL: begin
                exp_w = EXP_W'(BIAS - HALF_BIAS) + EXP_W'(fields_i.exp);
                man_w[MAN_W-1 -: HALF_MAN_W] = fields_i.frac;
            end
            CLS_SUB: begin
                exp_w = EXP_W'(BIAS - HALF_BIAS + 1) - EXP_W'(norm_steps_i);
                man_w[MAN_W-1 -: HALF_MAN_W] = norm_frac_i;
            end
            default: begin
                exp_w = '0;
            end
        endcase
        word_o = {fields_i.sign, exp_w, man_w};
    end

endmodule

// File: rtl/f16_widener.sv
module f16_widener
    import f16w_pkg::*;
#(
    parameter bit WIDE_DOUBLE = 1'b0,
    localparam int OUT_W = WIDE_DOUBLE ? 64 : 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [15:0]      half_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [OUT_W-1:0] result_o
);

    localparam int EXP_W = WIDE_DOUBLE ? 11 : 8;
    localparam int MAN_W = OUT_W - 1 - EXP_W;

    typedef struct packed {
        logic              done;
        logic [HALF_W-1:0] half;
        logic [OUT_W-1:0]  result;
    } top_state_t;

    top_state_t             st_d, st_q;
    half_fields_t           fld;
    logic [HALF_W-1:0]      src_word;
    logic                   accept;
    logic                   load_sub;
    logic                   n_active;
    logic                   n_finish;
    logic [HALF_MAN_W-1:0]  n_frac;
    logic [NORM_STEP_W-1:0] n_steps;
    logic [OUT_W-1:0]       packed_word;

    assign accept   = start_i && !n_active;
    assign src_word = n_active ? st_q.half : half_i;
    assign load_sub = accept && (fld.cls == CLS_SUB);

    f16w_classify u_classify (
        .word_i   (src_word),
        .fields_o (fld)
    );

    f16w_normalizer u_normalizer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load_sub),
        .frac_i   (fld.frac),
        .active_o (n_active),
        .finish_o (n_finish),
        .frac_o   (n_frac),
        .steps_o  (n_steps)
    );

    f16w_pack #(
        .EXP_W (EXP_W),
        .MAN_W (MAN_W)
    ) u_pack (
        .fields_i     (fld),
        .norm_frac_i  (n_frac),
        .norm_steps_i (n_steps),
        .word_o       (packed_word)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (n_finish) begin
            st_d.done   = 1'b1;
            st_d.result = packed_word;
        end else if (accept) begin
            st_d.half = half_i;
            if (fld.cls != CLS_SUB) begin
                st_d.done   = 1'b1;
                st_d.result = packed_word;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o   = n_active;
    assign done_o   = st_q.done;
    assign result_o = st_q.result;

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> !done_o);

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result_o) |-> done_o);

    // R8
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(st_q.half));

    // R10
    sign_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (result_o[OUT_W-1] == st_q.half[HALF_W-1]));

    // R5
    nan_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (&st_q.half[HALF_W-2 -: HALF_EXP_W]) && (|st_q.half[HALF_MAN_W-1:0]))
        |-> ((result_o[HALF_MAN_W-1:0] == st_q.half[HALF_MAN_W-1:0]) && (&result_o[OUT_W-2 -: EXP_W])));

    // R4
    inf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (&st_q.half[HALF_W-2 -: HALF_EXP_W]) && !(|st_q.half[HALF_MAN_W-1:0]))
        |-> ((result_o[MAN_W-1:0] == '0) && (&result_o[OUT_W-2 -: EXP_W])));

endmodule

// File: tb/test_f16_widener.sv
module test_f16_widener;

    localparam bit WIDE_DOUBLE = 1'b0;
    localparam int OUT_W = WIDE_DOUBLE ? 64 : 32;
    localparam int EXP_W = WIDE_DOUBLE ? 11 : 8;
    localparam int MAN_W = OUT_W - 1 - EXP_W;
    localparam int BIAS  = (1 << (EXP_W - 1)) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [15:0]      half_i = '0;
    logic             busy_o;
    logic             done_o;
    logic [OUT_W-1:0] result_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    f16_widener #(.WIDE_DOUBLE(WIDE_DOUBLE)) i_f16_widener (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .half_i   (half_i),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .result_o (result_o)
    );

    function automatic int msb_pos(input int f);
        int r = 0;
        for (int i = 0; i < 10; i++) if (f[i]) r = i;
        return r;
    endfunction

    function automatic logic [OUT_W-1:0] expect_wide(input logic [15:0] h);
        int e = int'(h[14:10]);
        int f = int'(h[9:0]);
        int p;
        logic [EXP_W-1:0] ew = '0;
        logic [MAN_W-1:0] mw = '0;
        if (e == 31) begin
            ew = '1;
            if (f != 0) mw[9:0] = h[9:0];
        end else if (e == 0) begin
            if (f != 0) begin
                p = msb_pos(f);
                ew = EXP_W'(BIAS - 24 + p);
                mw[MAN_W-1 -: 10] = 10'((f << (10 - p)) & 'h3ff);
            end
        end else begin
            ew = EXP_W'(e - 15 + BIAS);
            mw[MAN_W-1 -: 10] = h[9:0];
        end
        return {h[15], ew, mw};
    endfunction

    function automatic int expect_lat(input logic [15:0] h);
        if (h[14:10] == 5'd0 && h[9:0] != 10'd0) return 11 - msb_pos(int'(h[9:0]));
        return 1;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic convert(input logic [15:0] h, input string req);
        int n = 1;
        int lat = expect_lat(h);
        logic [OUT_W-1:0] exp_r = expect_wide(h);
        @(negedge clk);
        start_i = 1'b1;
        half_i  = h;
        @(negedge clk);
        start_i = 1'b0;
        half_i  = ~h;
        if (lat > 1) check(busy_o == 1'b1, "R7", "busy during loop", 64'(busy_o), 64'd1);
        while (!done_o && n < 16) begin
            @(negedge clk);
            n++;
        end
        check(n == lat, (lat > 1) ? "R7" : req, "latency", 64'(n), 64'(lat));
        check(result_o == exp_r, req, "value", 64'(result_o), 64'(exp_r));
        check(result_o[OUT_W-1] == h[15], "R10", "sign", 64'(result_o[OUT_W-1]), 64'(h[15]));
        @(negedge clk);
        check(!done_o && !busy_o, "R9", "done pulse width", 64'({done_o, busy_o}), 64'd0);
        check(result_o == exp_r, "R9", "result hold", 64'(result_o), 64'(exp_r));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog all-requirements actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        logic [OUT_W-1:0] first_r;
        repeat (3) @(negedge clk);
        // R1 during reset
        check(!done_o && !busy_o && result_o == '0, "R1", "reset outputs",
              64'(result_o), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!done_o && !busy_o && result_o == '0, "R1", "after release",
              64'(result_o), 64'd0);

        convert(16'h0000, "R2");
        convert(16'h8000, "R2");
        convert(16'h7C00, "R4");
        convert(16'hFC00, "R4");
        convert(16'h7C01, "R5");
        convert(16'h7E00, "R5");
        convert(16'hFFFF, "R5");
        convert(16'h3C00, "R3");
        if (!WIDE_DOUBLE)
            check(result_o == OUT_W'(32'h3F80_0000), "R3", "one anchor",
                  64'(result_o), 64'h3F80_0000);
        convert(16'h7BFF, "R3");
        convert(16'h0400, "R3");
        convert(16'h0001, "R11");
        if (!WIDE_DOUBLE)
            check(result_o == OUT_W'(32'h3380_0000), "R11", "smallest subnormal anchor",
                  64'(result_o), 64'h3380_0000);

        // exhaustive sweep of zero and subnormal encodings (R6)
        for (int s = 0; s < 2; s++)
            for (int f = 0; f < 1024; f++)
                convert({1'(s), 5'd0, 10'(f)}, (f == 0) ? "R2" : "R6");

        // strided sweep over every nonzero exponent (R3, R4, R5)
        for (int s = 0; s < 2; s++)
            for (int e = 1; e < 32; e++)
                for (int f = 0; f < 1024; f += 5)
                    convert({1'(s), 5'(e), 10'(f)},
                            (e == 31) ? ((f == 0) ? "R4" : "R5") : "R3");

        // R8: overlapping start during a long normalization
        first_r = expect_wide(16'h0001);
        @(negedge clk);
        start_i = 1'b1;
        half_i  = 16'h0001;
        @(negedge clk);
        start_i = 1'b0;
        n = 1;
        @(negedge clk); n++;
        check(busy_o == 1'b1, "R8", "busy before overlap", 64'(busy_o), 64'd1);
        start_i = 1'b1;
        half_i  = 16'h3C00;
        @(negedge clk); n++;
        start_i = 1'b0;
        while (!done_o && n < 16) begin
            @(negedge clk);
            n++;
        end
        check(n == 11, "R8", "latency with overlap", 64'(n), 64'd11);
        check(result_o == first_r, "R8", "value with overlap", 64'(result_o), 64'(first_r));
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(!done_o && result_o == first_r, "R8", "dropped start stays silent",
                  64'(result_o), 64'(first_r));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule